// File: doc/BRIEF.md
# Pending MSI Vector Scanner

This block services one group of message-signalled interrupt termination registers. When the group's interrupt line fires, a start pulse launches a scan. The scanner reads the group's summary register, whose low bits mark which index registers hold pending messages. It fetches those index registers one at a time, lowest first. For every set bit in an index value it emits one vector number on a valid/ready stream, lowest bit first.

Each vector number combines the index, the bit position and the group. It is then folded down to a canonical number, so that all per-core aliases of one vector map to the same value. Register contents arrive through a simple request/acknowledge read port; the register bank itself sits outside the block.

When the local copy of the summary runs out, the summary register is read again. This catches messages that landed during the scan. The scan ends, with a one-cycle done pulse, only after a fresh summary read returns zero.

Top module: `msi_scan`

## Requirements
- R1: During reset and whenever `busy_o` is low, `rd_req_o`, `vec_valid_o` and `done_o` are low (except the one-cycle `done_o` of R8) and `busy_o` is low after reset.
- R2: `start_i` is accepted only while `busy_o` is low, including the cycle in which `done_o` is high. `grp_i` and `core_log2_i` are captured at that moment. A start while busy has no effect on reads, vectors or the group used.
- R3: The first read after an accepted start is a summary read (`rd_sum_o`=1). Bits [7:0] of the returned data mark pending index registers 0..7, and bits [15:8] are ignored. Index registers are read in ascending order, each once per summary value, with `rd_sum_o`=0 and the register number on `rd_idx_o`.
- R4: For each index-register value, one vector is emitted per set bit, lowest bit position first, and none for clear bits.
- R5: The raw vector is ((index*16 + bit)*16 + group), 11 bits wide.
- R6: The emitted vector is raw - (raw mod 2^k), where k is the captured `core_log2_i`. k ranges 0..4, and values above 4 act as 4.
- R7: After the last pending index of a summary value has been handled, the summary register is read again. A nonzero value continues the scan in the same way.
- R8: When a summary read returns zero in its low 8 bits, `done_o` is high for exactly one cycle, in the cycle after that acknowledge, and `busy_o` is low in that cycle.
- R9: While `vec_valid_o` is high and `vec_ready_i` is low, `vec_valid_o` stays high and `vec_o` keeps its value in the next cycle.
- R10: `rd_req_o` stays high with `rd_sum_o` and `rd_idx_o` unchanged until the cycle in which `rd_ack_i` is high. `rd_data_i` is taken in that cycle, and the acknowledge may come one or more cycles after the request rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a scan (taken when idle) |
| grp_i | input | 4 | Group number folded into every vector |
| core_log2_i | input | 3 | log2 of the core count used for folding |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan end |
| rd_req_o | output | 1 | Register read request |
| rd_sum_o | output | 1 | 1: summary register, 0: index register |
| rd_idx_o | output | 3 | Index register number for the read |
| rd_ack_i | input | 1 | Read acknowledge, data valid this cycle |
| rd_data_i | input | 16 | Read data |
| vec_valid_o | output | 1 | Vector available |
| vec_ready_i | input | 1 | Consumer accepts vector |
| vec_o | output | 11 | Canonical vector number |

## Verification
The end of one scan and the start of the next can share a cycle: `done_o` is high while the block is already idle, so a start in that cycle must be taken. The bench raises `start_i` exactly on the `done_o` cycle with new register contents, and expects the next read to be a summary read with vectors built from the new group. It also pulses start mid-scan with a different group and core count, and expects both the vector list and the read order to match the first start alone.

// File: rtl/msi_scan_pkg.sv
package msi_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SUM,
        ST_PICK,
        ST_RD_IDX,
        ST_EMIT
    } scan_st_e;

endpackage

// File: rtl/msi_ffs.sv
// Lowest-set-bit finder for a W-bit word.
module msi_ffs #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] pos_o
);

    always_comb begin
        found_o = |vec_i;
        pos_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                pos_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/msi_vec_map.sv
// Builds the raw vector number and folds it to its canonical alias.
module msi_vec_map #(
    parameter int IDX_W = 3,
    parameter int BIT_W = 4,
    parameter int GRP_W = 4,
    parameter int KL_W  = 3,
    parameter int VEC_W = 11
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [BIT_W-1:0] bit_i,
    input  logic [GRP_W-1:0] grp_i,
    input  logic [KL_W-1:0]  kl_i,
    output logic [VEC_W-1:0] vec_o
);

    localparam int BIT_N = 1 << BIT_W;
    localparam int GRP_N = 1 << GRP_W;

    logic [VEC_W-1:0] raw;
    logic [VEC_W-1:0] low_mask;

    always_comb begin
        raw      = ((VEC_W'(idx_i) * VEC_W'(BIT_N) + VEC_W'(bit_i)) * VEC_W'(GRP_N))
                   + VEC_W'(grp_i);
        low_mask = (VEC_W'(1) << kl_i) - VEC_W'(1);
        vec_o    = raw & ~low_mask;
    end

endmodule

// File: rtl/msi_scan.sv
module msi_scan
    import msi_scan_pkg::*;
#(
    parameter  int IDX_N         = 8,
    parameter  int BIT_N         = 16,
    parameter  int GRP_N         = 16,
    parameter  int CORE_LOG2_MAX = 4,
    localparam int IDX_W         = $clog2(IDX_N),
    localparam int BIT_W         = $clog2(BIT_N),
    localparam int GRP_W         = $clog2(GRP_N),
    localparam int KL_W          = $clog2(CORE_LOG2_MAX + 1),
    localparam int VEC_W         = IDX_W + BIT_W + GRP_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [GRP_W-1:0] grp_i,
    input  logic [KL_W-1:0]  core_log2_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             rd_req_o,
    output logic             rd_sum_o,
    output logic [IDX_W-1:0] rd_idx_o,
    input  logic             rd_ack_i,
    input  logic [BIT_N-1:0] rd_data_i,
    output logic             vec_valid_o,
    input  logic             vec_ready_i,
    output logic [VEC_W-1:0] vec_o
);

    typedef struct packed {
        scan_st_e         st;
        logic [IDX_N-1:0] sum;
        logic [IDX_W-1:0] idx;
        logic [BIT_N-1:0] bits;
        logic [GRP_W-1:0] grp;
        logic [KL_W-1:0]  kl;
        logic             done;
    } scan_regs_t;

    localparam scan_regs_t RST_VAL = '0;

    scan_regs_t q, d;

    logic             sum_found;
    logic [IDX_W-1:0] sum_pos;
    logic             bit_found;
    logic [BIT_W-1:0] bit_pos;
    logic [GRP_W-1:0] grp_cur;
    logic [KL_W-1:0]  kl_cur;
    logic [KL_W-1:0]  kl_clamp;

    assign grp_cur  = q.grp;
    assign kl_cur   = q.kl;
    assign kl_clamp = (core_log2_i > KL_W'(CORE_LOG2_MAX)) ? KL_W'(CORE_LOG2_MAX) : core_log2_i;

    msi_ffs #(.W(IDX_N), .IW(IDX_W)) u_sum_ffs (
        .vec_i   (q.sum),
        .found_o (sum_found),
        .pos_o   (sum_pos)
    );

    msi_ffs #(.W(BIT_N), .IW(BIT_W)) u_bit_ffs (
        .vec_i   (q.bits),
        .found_o (bit_found),
        .pos_o   (bit_pos)
    );

    msi_vec_map #(
        .IDX_W (IDX_W),
        .BIT_W (BIT_W),
        .GRP_W (GRP_W),
        .KL_W  (KL_W),
        .VEC_W (VEC_W)
    ) u_map (
        .idx_i (q.idx),
        .bit_i (bit_pos),
        .grp_i (grp_cur),
        .kl_i  (kl_cur),
        .vec_o (vec_o)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st  = ST_RD_SUM;
                    d.grp = grp_i;
                    d.kl  = kl_clamp;
                end
            end
            ST_RD_SUM: begin
                if (rd_ack_i) begin
                    d.sum = rd_data_i[IDX_N-1:0];
                    if (rd_data_i[IDX_N-1:0] == '0) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_PICK;
                    end
                end
            end
            ST_PICK: begin
                if (sum_found) begin
                    d.idx = sum_pos;
                    d.sum = q.sum & ~(IDX_N'(1) << sum_pos);
                    d.st  = ST_RD_IDX;
                end else begin
                    d.st = ST_RD_SUM;
                end
            end
            ST_RD_IDX: begin
                if (rd_ack_i) begin
                    d.bits = rd_data_i;
                    d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (!bit_found) begin
                    d.st = ST_PICK;
                end else if (vec_ready_i) begin
                    d.bits = q.bits & ~(BIT_N'(1) << bit_pos);
                end
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign rd_req_o    = (q.st == ST_RD_SUM) || (q.st == ST_RD_IDX);
    assign rd_sum_o    = (q.st == ST_RD_SUM);
    assign rd_idx_o    = q.idx;
    assign vec_valid_o = (q.st == ST_EMIT) && bit_found;

endmodule

// File: rtl/msi_scan_chk.sv
module msi_scan_chk #(
    parameter int IDX_N = 8,
    parameter int IDX_W = 3,
    parameter int GRP_W = 4,
    parameter int KL_W  = 3,
    parameter int VEC_W = 11
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             rd_req_o,
    input logic             rd_sum_o,
    input logic [IDX_W-1:0] rd_idx_o,
    input logic             rd_ack_i,
    input logic [IDX_N-1:0] sum_data_i,
    input logic             vec_valid_o,
    input logic             vec_ready_i,
    input logic [VEC_W-1:0] vec_o,
    input logic [GRP_W-1:0] grp_cur,
    input logic [KL_W-1:0]  kl_cur
);

    logic [VEC_W-1:0] alias_bits;
    assign alias_bits = (VEC_W'(1) << kl_cur) - VEC_W'(1);

    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!rd_req_o && !vec_valid_o));

    assert_first_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (rd_req_o && rd_sum_o));

    assert_group_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && kl_cur == '0) |-> (vec_o[GRP_W-1:0] == grp_cur));

    assert_canonical_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o |-> ((vec_o & alias_bits) == '0));

    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(rd_ack_i && rd_sum_o && (sum_data_i == '0)) && !busy_o));

    assert_vec_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_o)));

    assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_sum_o) && $stable(rd_idx_o)));

endmodule

bind msi_scan msi_scan_chk #(
    .IDX_N (IDX_N),
    .IDX_W (IDX_W),
    .GRP_W (GRP_W),
    .KL_W  (KL_W),
    .VEC_W (VEC_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rd_req_o    (rd_req_o),
    .rd_sum_o    (rd_sum_o),
    .rd_idx_o    (rd_idx_o),
    .rd_ack_i    (rd_ack_i),
    .sum_data_i  (rd_data_i[IDX_N-1:0]),
    .vec_valid_o (vec_valid_o),
    .vec_ready_i (vec_ready_i),
    .vec_o       (vec_o),
    .grp_cur     (grp_cur),
    .kl_cur      (kl_cur)
);

// File: tb/msi_scan_bench.sv
module msi_scan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  grp = '0;
    logic [2:0]  kl = '0;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic        vrdy = 1'b0;
    wire         busy, done, rd_req, rd_sum, vvld;
    wire  [2:0]  rd_idx;
    wire  [10:0] vec;

    always #4 clk = ~clk;

    msi_scan u_msi_scan (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .grp_i       (grp),
        .core_log2_i (kl),
        .busy_o      (busy),
        .done_o      (done),
        .rd_req_o    (rd_req),
        .rd_sum_o    (rd_sum),
        .rd_idx_o    (rd_idx),
        .rd_ack_i    (rd_ack),
        .rd_data_i   (rd_data),
        .vec_valid_o (vvld),
        .vec_ready_i (vrdy),
        .vec_o       (vec)
    );

    int total = 0;
    int bad = 0;

    logic [7:0]  sum_seq [4];
    int          n_sum = 0;
    logic [15:0] idx_val [4][8];
    int          rdy_pct = 100;
    int          dly_max = 0;
    int          sum_reads = 0;
    int          got_vec [$];
    int          got_rd [$];
    int          exp_vec [$];
    int          exp_rd [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        n_sum = 0;
        for (int p = 0; p < 4; p++) begin
            sum_seq[p] = '0;
            for (int i = 0; i < 8; i++) idx_val[p][i] = '0;
        end
    endtask

    function automatic int canon(input int i, input int b, input int g, input int k);
        int raw;
        int kk;
        raw = (i * 16 + b) * 16 + g;
        kk  = (k > 4) ? 4 : k;
        return raw - (raw % (1 << kk));
    endfunction

    task automatic prep(input int g, input int k);
        exp_vec.delete();
        exp_rd.delete();
        got_vec.delete();
        got_rd.delete();
        sum_reads = 0;
        for (int p = 0; p <= n_sum; p++) begin
            logic [7:0] s;
            s = (p < n_sum) ? sum_seq[p] : 8'h00;
            exp_rd.push_back(-1);
            if (s == 8'h00) break;
            for (int i = 0; i < 8; i++) begin
                if (s[i]) begin
                    exp_rd.push_back(i);
                    for (int b = 0; b < 16; b++)
                        if (idx_val[p][i][b]) exp_vec.push_back(canon(i, b, g, k));
                end
            end
        end
    endtask

    task automatic launch(input int g, input int k);
        start = 1'b1;
        grp   = 4'(g);
        kl    = 3'(k);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int c;
        c = 0;
        while (!done) begin
            @(negedge clk);
            c++;
            if (c > 20000) begin
                chk(1'b0, "R8 done timeout", c, 0);
                break;
            end
        end
    endtask

    task automatic compare(input string vtag, input string rtag);
        chk(got_rd.size() == exp_rd.size(), rtag, got_rd.size(), exp_rd.size());
        for (int i = 0; i < exp_rd.size() && i < got_rd.size(); i++)
            chk(got_rd[i] == exp_rd[i], rtag, got_rd[i], exp_rd[i]);
        chk(got_vec.size() == exp_vec.size(), vtag, got_vec.size(), exp_vec.size());
        for (int i = 0; i < exp_vec.size() && i < got_vec.size(); i++)
            chk(got_vec[i] == exp_vec[i], vtag, got_vec[i], exp_vec[i]);
    endtask

    task automatic scan(input int g, input int k, input string vtag, input string rtag);
        prep(g, k);
        launch(g, k);
        wait_done();
        compare(vtag, rtag);
        @(negedge clk);
    endtask

    // read responder, vector sink and handshake hold checks
    initial begin
        int   wcnt = 0;
        int   dly = -1;
        bit   prev_pend = 1'b0;
        bit   prev_hold = 1'b0;
        bit   prev_done = 1'b0;
        logic prev_sum = 1'b0;
        logic [2:0]  prev_idx = '0;
        logic [10:0] prev_vec = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rd_ack = 1'b0;
                vrdy = 1'b0;
                prev_pend = 1'b0;
                prev_hold = 1'b0;
                prev_done = 1'b0;
                continue;
            end
            if (prev_pend)
                chk(rd_req && rd_sum == prev_sum && rd_idx == prev_idx, "R10",
                    {rd_req, rd_sum, rd_idx}, {1'b1, prev_sum, prev_idx});
            if (prev_hold)
                chk(vvld && vec == prev_vec, "R9", vvld ? int'(vec) : -1, prev_vec);
            if (prev_done)
                chk(!done, "R8 pulse width", done, 0);
            prev_done = done;
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (dly < 0) dly = $urandom_range(0, dly_max);
                if (wcnt >= dly) begin
                    if (rd_sum) begin
                        got_rd.push_back(-1);
                        rd_data = {8'($urandom), (sum_reads < n_sum) ? sum_seq[sum_reads] : 8'h00};
                        sum_reads++;
                    end else begin
                        got_rd.push_back(int'(rd_idx));
                        rd_data = (sum_reads >= 1 && sum_reads <= n_sum) ?
                                  idx_val[sum_reads-1][rd_idx] : 16'h0000;
                    end
                    rd_ack = 1'b1;
                    wcnt = 0;
                    dly = -1;
                end else begin
                    wcnt++;
                end
            end
            prev_pend = rd_req && !rd_ack;
            prev_sum  = rd_sum;
            prev_idx  = rd_idx;
            vrdy = ($urandom_range(0, 99) < rdy_pct);
            if (vvld && vrdy) got_vec.push_back(int'(vec));
            prev_hold = vvld && !vrdy;
            prev_vec  = vec;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clr();
        repeat (3) @(negedge clk);
        chk(!busy && !rd_req && !vvld && !done, "R1 in reset", {busy, rd_req, vvld, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_req && !vvld && !done, "R1 after reset", {busy, rd_req, vvld, done}, 0);

        // zero summary: immediate finish
        clr();
        scan(3, 0, "R8", "R8");

        // extreme positions, no folding
        clr();
        n_sum = 1;
        sum_seq[0] = 8'h81;
        idx_val[0][0] = 16'h0001;
        idx_val[0][7] = 16'h8000;
        scan(15, 0, "R5", "R3");
        // folding: k=3 -> 8, 2040; k=4 -> 0, 2032; k=7 clamps to 4
        scan(15, 3, "R6", "R3");
        scan(15, 4, "R6", "R3");
        scan(15, 7, "R6", "R3");

        // second summary pass continues the scan
        clr();
        n_sum = 2;
        sum_seq[0] = 8'h24;
        idx_val[0][2] = 16'h00F0;
        idx_val[0][5] = 16'h0003;
        sum_seq[1] = 8'h02;
        idx_val[1][1] = 16'hA000;
        dly_max = 2;
        scan(6, 1, "R4", "R7");

        // consumer stalls often
        rdy_pct = 10;
        scan(9, 2, "R9", "R3");
        rdy_pct = 100;

        // start while busy is ignored
        clr();
        n_sum = 1;
        sum_seq[0] = 8'h10;
        idx_val[0][4] = 16'h0505;
        dly_max = 3;
        prep(5, 0);
        launch(5, 0);
        start = 1'b1;
        grp = 4'd9;
        kl = 3'd4;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        compare("R2", "R2");
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !rd_req, "R2 no second scan", {busy, rd_req}, 0);
        end

        // start in the done cycle is accepted
        prep(1, 0);
        launch(1, 0);
        wait_done();
        compare("R2", "R2");
        clr();
        n_sum = 1;
        sum_seq[0] = 8'h08;
        idx_val[0][3] = 16'h4002;
        prep(12, 0);
        launch(12, 0);
        wait_done();
        compare("R2", "R2");
        @(negedge clk);

        // constrained random scans
        for (int t = 0; t < 30; t++) begin
            int g;
            int k;
            clr();
            n_sum = $urandom_range(0, 3);
            for (int p = 0; p < n_sum; p++) begin
                sum_seq[p] = ($urandom_range(0, 5) == 0) ? 8'h00 : 8'($urandom);
                for (int i = 0; i < 8; i++)
                    idx_val[p][i] = 16'($urandom) & 16'($urandom);
            end
            g = $urandom_range(0, 15);
            k = $urandom_range(0, 7);
            rdy_pct = $urandom_range(30, 100);
            dly_max = $urandom_range(0, 3);
            scan(g, k, "R4", "R3");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule